// File: doc/BRIEF.md
# ID-Filtered Transaction Byte Counter Front End

This block sits between a memory port's address channels and a bank of event counters. It watches accepted read and write address handshakes. A handshake counts when its transaction ID passes a single shared ID/mask filter. For each such handshake the block raises a one-cycle strobe, one for reads and one for writes. The counter bank counts these strobes as bursts for its read-by-ID and write-by-ID events.

When built with the enhanced option, the block also keeps a byte total for each counter that has selected one of the two filtered events. Each burst adds (length + 1) shifted left by the beat size. These totals sit beside the burst counts and are read back at a small window of addresses. The lowest address of that window is also the filter register's write address. Counter 0 is the cycle counter, which never takes a filtered event, so its slot always reads zero. Without the enhanced option, the strobes still work and no bytes are kept.

Top module: `axid_traffic_filter`

## Requirements
- R1: After reset both strobes are low, every byte total reads zero, and the filter holds ID 0 with stored mask 0.
- R2: The filter register is written at address 0x30, with the ID in bits 15:0 and the stored mask in bits 31:16. The stored mask is the bitwise inverse of the user mask. A transaction ID matches when it equals the filter ID in every bit where the stored mask is 1.
- R3: `rd_id_hit` is high for exactly the one cycle after a cycle with `ar_valid` and `ar_ready` both high and a matching `ar_id`. Otherwise it is low, including when valid is high without ready.
- R4: `wr_id_hit` behaves the same way for `aw_valid`, `aw_ready` and `aw_id`.
- R5: Only counters whose 8-bit event code is 0x41 (read by ID) or 0x42 (write by ID) accumulate bytes. A counter with any other code keeps its total.
- R6: In enhanced mode, counter n (n ≥ 1) reads back at address 0x30 + 4·n. A matching burst adds (len + 1) << size to it, in the same cycle as the strobe.
- R7: Every counter uses the one shared filter, so two counters with the same filtered code gain identical amounts.
- R8: A read of address 0x30, which is counter 0's slot, always returns zero.
- R9: `cnt_clr[n]` zeroes counter n's total at the next edge, and it takes priority over a burst that lands in the same cycle.
- R10: A counter whose `cnt_en` bit is low keeps its total.
- R11: With the enhanced option off, the strobes behave as in R3/R4 and every readback address returns zero.
- R12: A register write to any address other than 0x30 leaves the filter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and combinational readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | BYTE_W | Byte total for the addressed counter slot |
| evt_sel | input | NUM_CNT*EVT_W | Event code for each counter; counter n uses bits n*EVT_W and up |
| cnt_en | input | NUM_CNT | Counter enables |
| cnt_clr | input | NUM_CNT | Counter clears |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 16 | Read transaction ID |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_size | input | SIZE_W | Read beat size, log2 of bytes |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | 16 | Write transaction ID |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_size | input | SIZE_W | Write beat size, log2 of bytes |
| rd_id_hit | output | 1 | Matching read burst strobe |
| wr_id_hit | output | 1 | Matching write burst strobe |

## Verification
The assertions assume that the handshake fields and the counter controls are stable and known at each rising edge. They also assume that `reg_addr` is a byte address with its low two bits naming nothing. The stimulus meets these assumptions by changing every input only on the falling edge and by using word-aligned addresses only. Handshakes last a single cycle, so each strobe maps to exactly one burst. The bench drives an enhanced and a plain instance from the same stimulus.

// File: rtl/axid_traffic_filter.sv
module axid_traffic_filter #(
  parameter int NUM_CNT  = 4,
  parameter int LEN_W    = 8,
  parameter int SIZE_W   = 3,
  parameter int BYTE_W   = 32,
  parameter int EVT_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int FLT_ADDR = 'h30,
  parameter int EV_RD    = 'h41,
  parameter int EV_WR    = 'h42,
  parameter bit ENHANCED = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [BYTE_W-1:0]        reg_rdata,
  input  logic [NUM_CNT*EVT_W-1:0] evt_sel,
  input  logic [NUM_CNT-1:0]       cnt_en,
  input  logic [NUM_CNT-1:0]       cnt_clr,
  input  logic                     ar_valid,
  input  logic                     ar_ready,
  input  logic [15:0]              ar_id,
  input  logic [LEN_W-1:0]         ar_len,
  input  logic [SIZE_W-1:0]        ar_size,
  input  logic                     aw_valid,
  input  logic                     aw_ready,
  input  logic [15:0]              aw_id,
  input  logic [LEN_W-1:0]         aw_len,
  input  logic [SIZE_W-1:0]        aw_size,
  output logic                     rd_id_hit,
  output logic                     wr_id_hit
);
  localparam int BURST_W = LEN_W + (1 << SIZE_W);

  logic [15:0] flt_id, flt_mask;
  logic        rd_match, wr_match;
  logic [BURST_W-1:0] rd_bytes, wr_bytes;
  logic [NUM_CNT*BYTE_W-1:0] totals;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_id   <= '0;
      flt_mask <= '0;
    end else if (reg_wr && reg_addr == ADDR_W'(FLT_ADDR)) begin
      flt_id   <= reg_wdata[15:0];
      flt_mask <= reg_wdata[31:16];
    end
  end

  assign rd_match = ar_valid && ar_ready && (((ar_id ^ flt_id) & flt_mask) == 16'h0);
  assign wr_match = aw_valid && aw_ready && (((aw_id ^ flt_id) & flt_mask) == 16'h0);

  assign rd_bytes = (BURST_W'(ar_len) + BURST_W'(1)) << ar_size;
  assign wr_bytes = (BURST_W'(aw_len) + BURST_W'(1)) << aw_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_id_hit <= 1'b0;
      wr_id_hit <= 1'b0;
    end else begin
      rd_id_hit <= rd_match;
      wr_id_hit <= wr_match;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    if (n == 0 || !ENHANCED) begin : g_zero
      assign totals[n*BYTE_W +: BYTE_W] = '0;
    end else begin : g_acc
      logic [EVT_W-1:0]  sel;
      logic [BYTE_W-1:0] acc, add;
      assign sel = evt_sel[n*EVT_W +: EVT_W];
      assign add = (sel == EVT_W'(EV_RD) && rd_match) ? BYTE_W'(rd_bytes) :
                   (sel == EVT_W'(EV_WR) && wr_match) ? BYTE_W'(wr_bytes) : '0;
      always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr[n]) acc <= '0;
        else if (cnt_en[n])        acc <= acc + add;
      end
      assign totals[n*BYTE_W +: BYTE_W] = acc;

      assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_clr[n]) |-> acc == '0);
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_en[n]) && !$past(cnt_clr[n])) |-> $stable(acc));
      assert_other_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) != EVT_W'(EV_RD) && $past(sel) != EVT_W'(EV_WR) && !$past(cnt_clr[n]))
          |-> $stable(acc));
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_CNT; n++)
      if (reg_addr == ADDR_W'(FLT_ADDR + 4*n)) reg_rdata = totals[n*BYTE_W +: BYTE_W];
  end

  assert_rd_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id_hit |-> $past(ar_valid && ar_ready));
  assert_wr_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_id_hit |-> $past(aw_valid && aw_ready));
  assert_masked_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(((ar_id ^ flt_id) & flt_mask) != 16'h0) |-> !rd_id_hit);
  assert_slot0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ADDR_W'(FLT_ADDR) |-> reg_rdata == '0);
  if (!ENHANCED) begin : g_basic_chk
    assert_basic_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata == '0);
  end
endmodule

// File: tb/axid_traffic_filter_tb.sv
module axid_traffic_filter_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 8'h30;
  logic [31:0] reg_wdata = 0;
  logic [31:0] rdata_e, rdata_b;
  logic [31:0] evt_sel = {8'h41, 8'h42, 8'h41, 8'h00};
  logic [3:0]  cnt_en = 4'hF, cnt_clr = 4'h0;
  logic        ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
  logic [15:0] ar_id = 0, aw_id = 0;
  logic [7:0]  ar_len = 0, aw_len = 0;
  logic [2:0]  ar_size = 0, aw_size = 0;
  logic rd_e, wr_e, rd_b, wr_b;

  int checks = 0, errors = 0;
  logic [31:0] expc [4];

  axid_traffic_filter u_dut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata(rdata_e),
    .evt_sel, .cnt_en, .cnt_clr, .ar_valid, .ar_ready, .ar_id, .ar_len, .ar_size,
    .aw_valid, .aw_ready, .aw_id, .aw_len, .aw_size, .rd_id_hit(rd_e), .wr_id_hit(wr_e));
  axid_traffic_filter #(.ENHANCED(1'b0)) u_basic (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata(rdata_b), .evt_sel, .cnt_en, .cnt_clr, .ar_valid, .ar_ready, .ar_id, .ar_len,
    .ar_size, .aw_valid, .aw_ready, .aw_id, .aw_len, .aw_size, .rd_id_hit(rd_b), .wr_id_hit(wr_b));

  // {user_mask, flt_id, txn_id, is_wr, len, size, hit}
  localparam logic [60:0] VEC [8] = '{
    {16'h0000, 16'h1234, 16'h1234, 1'b0, 8'd3,   3'd2, 1'b1},
    {16'h0000, 16'h1234, 16'h1235, 1'b0, 8'd7,   3'd2, 1'b0},
    {16'h00FF, 16'h1200, 16'h12AB, 1'b0, 8'd0,   3'd0, 1'b1},
    {16'h00FF, 16'h1200, 16'h13AB, 1'b1, 8'd7,   3'd2, 1'b0},
    {16'hFFFF, 16'h0000, 16'hBEEF, 1'b1, 8'd255, 3'd7, 1'b1},
    {16'hFFF0, 16'h0005, 16'hFFF5, 1'b1, 8'd1,   3'd3, 1'b1},
    {16'hFFF0, 16'h0005, 16'h0004, 1'b0, 8'd7,   3'd2, 1'b0},
    {16'h7FFF, 16'h8000, 16'h8001, 1'b0, 8'd15,  3'd4, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic set_filter(input logic [15:0] umask, input logic [15:0] id, input logic [7:0] addr);
    @(negedge clk);
    reg_wr = 1; reg_addr = addr; reg_wdata = {umask ^ 16'hFFFF, id};
    @(negedge clk);
    reg_wr = 0; reg_addr = 8'h30;
  endtask

  task automatic check_totals(input string req);
    for (int n = 0; n < 4; n++) begin
      reg_addr = 8'h30 + 8'(4*n);
      #1;
      chk(req, rdata_e, expc[n]);
      chk("R11", rdata_b, 0);
    end
    reg_addr = 8'h30;
  endtask

  task automatic burst(input logic is_wr, input logic [15:0] id, input logic [7:0] len,
                       input logic [2:0] size, input logic ready, input logic hit, input string req);
    logic [31:0] b;
    b = (32'(len) + 1) << size;
    @(negedge clk);
    if (is_wr) begin aw_valid = 1; aw_ready = ready; aw_id = id; aw_len = len; aw_size = size; end
    else       begin ar_valid = 1; ar_ready = ready; ar_id = id; ar_len = len; ar_size = size; end
    for (int n = 1; n < 4; n++) begin
      if (cnt_clr[n]) expc[n] = 0;
      else if (cnt_en[n] && hit && evt_sel[n*8 +: 8] == (is_wr ? 8'h42 : 8'h41)) expc[n] += b;
    end
    @(negedge clk);
    ar_valid = 0; aw_valid = 0; ar_ready = 0; aw_ready = 0; cnt_clr = 0;
    chk(is_wr ? "R4" : "R3", {30'd0, wr_e, rd_e}, is_wr ? {30'd0, hit, 1'b0} : {31'd0, hit});
    chk("R11", {30'd0, wr_b, rd_b}, is_wr ? {30'd0, hit, 1'b0} : {31'd0, hit});
    check_totals(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_sim();
  end

  initial begin
    for (int n = 0; n < 4; n++) expc[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {30'd0, wr_e, rd_e}, 0);
    check_totals("R1");
    // R1: reset filter (stored mask 0) passes any ID
    burst(1'b0, 16'hABCD, 8'd0, 3'd1, 1'b1, 1'b1, "R1");

    for (int i = 0; i < 8; i++) begin
      set_filter(VEC[i][60:45], VEC[i][44:29], 8'h30);
      burst(VEC[i][12], VEC[i][28:13], VEC[i][11:4], VEC[i][3:1], 1'b1, VEC[i][0], "R6");
      chk("R7", expc[3], expc[1]);
    end

    // R2: exact match filter, handshake without ready gives no strobe (R3)
    set_filter(16'h0000, 16'h1234, 8'h30);
    burst(1'b0, 16'h1234, 8'd3, 3'd0, 1'b0, 1'b0, "R3");
    burst(1'b0, 16'h1234, 8'd3, 3'd0, 1'b1, 1'b1, "R2");

    // R12: write elsewhere leaves filter alone
    set_filter(16'hFFFF, 16'h0000, 8'h34);
    burst(1'b0, 16'h0000, 8'd1, 3'd1, 1'b1, 1'b0, "R12");

    // R10: disabled counter holds
    cnt_en = 4'b0111;
    burst(1'b0, 16'h1234, 8'd2, 3'd2, 1'b1, 1'b1, "R10");
    cnt_en = 4'hF;

    // R5: other event code ignores filtered traffic
    evt_sel[31:24] = 8'h04;
    burst(1'b0, 16'h1234, 8'd5, 3'd1, 1'b1, 1'b1, "R5");
    evt_sel[31:24] = 8'h41;

    // R9: clear wins over same-cycle burst
    cnt_clr = 4'b0010;
    burst(1'b0, 16'h1234, 8'd4, 3'd3, 1'b1, 1'b1, "R9");
    chk("R9", expc[1], 0);

    // R8: slot 0 stays zero after traffic
    reg_addr = 8'h30; #1;
    chk("R8", rdata_e, 0);
    burst(1'b1, 16'h1234, 8'd0, 3'd2, 1'b1, 1'b1, "R4");

    finish_sim();
  end
endmodule